// File: doc/BRIEF.md
# Monochrome Hardware Cursor Overlay

This block places a 64x64 two-plane cursor on top of an outgoing stream of 32-bit pixels, one scanline at a time. Software programs a small register file with the cursor position, a hot-spot adjustment, an image base offset, two 24-bit colours and an enable bit. At the start of each line the timing logic pulses `lineStart` with the line number. If the line falls inside the cursor, the block reads that cursor row's 16 image bytes over a simple read port with one cycle of latency. The bytes go into a line buffer during horizontal blanking.

During the active part of the line, each pixel enters with its column number and leaves one clock later. A pixel under the cursor is replaced by a cursor colour, inverted, or passed through unchanged, as its two mask bits decide. Pixels at or beyond the display width are never touched, so the cursor does not wrap onto the next line.

A lock bit lets software rewrite the base, position and hot-spot registers without the picture tearing. While the lock is set, drawing keeps using the values that were in force before it. Clearing the lock applies all pending values together.

Top module: `cursorOverlay`

## Requirements
- R1: After reset, every register reads 0 and pixels pass through unchanged.
- R2: A cursor pixel whose AND bit is 0 outputs `{colour, 8'hFF}`. The colour is colour 1 (register 5) when the XOR bit is 1 and colour 0 (register 4) when it is 0. Each colour is the low 24 bits of its register.
- R3: A cursor pixel with AND=1 and XOR=1 outputs the bitwise complement of the input pixel.
- R4: A cursor pixel with AND=1 and XOR=0 outputs the input pixel unchanged.
- R5: Image byte b of a row (0..15) is at row address + b. Bytes 0..7 form the AND plane and bytes 8..15 form the XOR plane. Cursor column c uses byte c/8 of each plane, bit 7-(c mod 8), so the most significant bit is the leftmost pixel.
- R6: A line is drawn only when the enable bit (register 0, bit 0) is set and the line number lies in Y..Y+63. Otherwise no memory read is issued and every pixel of the line passes through.
- R7: A cursor pixel is drawn only when its column is below `dispWidth`; columns at or above it pass through.
- R8: With the enable bit clear, every pixel passes through unchanged.
- R9: A write of bit 31 to the base (register 1), position (register 2) or hot-spot (register 3) register sets or clears the lock to that bit's value. While the lock is set, drawing uses the base, position and hot-spot values in force before it was set. Clearing it applies the pending values.
- R10: Register writes are masked on readback:
  - base: 0x87FFFFF0, with bit 31 the lock;
  - position: X in bits 29:16 and Y in bits 11:0;
  - hot-spot: X offset in bits 5:0 and Y offset in bits 21:16;
  - colours: 0x00FFFFFF.
  Position and hot-spot reads also return the lock in bit 31.
- R11: Row r of the cursor starts at byte address base - hotX - 16*hotY + 16*r.
- R12: Every valid input pixel produces exactly one valid output pixel exactly one clock later, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register select: 0 control, 1 base, 2 position, 3 hot-spot, 4 colour 0, 5 colour 1 |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Read data of the selected register (combinational) |
| lineStart | input | 1 | Pulse at the start of horizontal blanking |
| lineY | input | 12 | Number of the line that follows |
| dispWidth | input | 14 | Active display width in pixels |
| memRdEn | output | 1 | Image read request |
| memAddr | output | 27 | Image byte address |
| memRdData | input | 8 | Read data, one clock after the request |
| pixInValid | input | 1 | Input pixel valid |
| pixX | input | 14 | Column of the input pixel |
| pixIn | input | 32 | Input pixel |
| pixOutValid | output | 1 | Output pixel valid |
| pixOut | output | 32 | Output pixel |

## Verification
The bound checker watches four things on every cycle:
- the one-clock latency of the pixel stream;
- pass-through when the cursor is disabled or the column is clipped;
- that effective values stay frozen while the lock is held;
- that no fetch starts for lines above the cursor, and that each row fetch walks consecutive byte addresses.

The plane decode, the colour format, bit order within each byte, the hot-spot arithmetic, the register masks and the lower vertical limit depend on image contents and register history. Only the scoreboard scenarios can show those, because they compare every output pixel against a model computed from the written registers and the memory pattern.

// File: rtl/cursorPkg.sv
package cursorPkg;
  localparam int CUR_DIM   = 64;
  localparam int ROW_BYTES = 2 * CUR_DIM / 8;
  localparam int IDX_W     = $clog2(ROW_BYTES);
  localparam int ROW_W     = $clog2(CUR_DIM);
  localparam int HOT_W     = 6;
  localparam int CLR_W     = 24;

  typedef enum logic [2:0] {
    RA_CTRL = 3'd0,
    RA_BASE = 3'd1,
    RA_POS  = 3'd2,
    RA_HOT  = 3'd3,
    RA_CLR0 = 3'd4,
    RA_CLR1 = 3'd5
  } regSel_e;

  typedef struct packed {
    logic             clrRow;
    logic             ldByte;
    logic [IDX_W-1:0] byteIdx;
  } fetchStrobe_t;
endpackage

// File: rtl/cursorCtrl.sv
module cursorCtrl
  import cursorPkg::*;
#(
  parameter int ADDR_W = 27,
  parameter int X_W    = 14,
  parameter int Y_W    = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [2:0]        regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  logic              lineStart,
  input  logic [Y_W-1:0]    lineY,
  output logic              memRdEn,
  output logic [ADDR_W-1:0] memAddr,
  output fetchStrobe_t      strobe,
  output logic              enable,
  output logic [X_W-1:0]    effX,
  output logic [CLR_W-1:0]  color0,
  output logic [CLR_W-1:0]  color1
);
  localparam int ALIGN_W = IDX_W;
  localparam int BASE_W  = ADDR_W - ALIGN_W;

  logic              lockReg;
  logic [BASE_W-1:0] baseReg, effBase;
  logic [X_W-1:0]    xReg;
  logic [Y_W-1:0]    yReg, effY;
  logic [HOT_W-1:0]  hxReg, hyReg, effHx, effHy;
  logic              unusedWrBits;

  assign unusedWrBits = ^regWrData;

  // Register file and effective copies, which are frozen while the lock is set
  always_ff @(posedge clk) begin
    if (!rstN) begin
      enable  <= 1'b0;
      lockReg <= 1'b0;
      baseReg <= '0;
      xReg    <= '0;
      yReg    <= '0;
      hxReg   <= '0;
      hyReg   <= '0;
      color0  <= '0;
      color1  <= '0;
      effBase <= '0;
      effX    <= '0;
      effY    <= '0;
      effHx   <= '0;
      effHy   <= '0;
    end else begin
      if (!lockReg) begin
        effBase <= baseReg;
        effX    <= xReg;
        effY    <= yReg;
        effHx   <= hxReg;
        effHy   <= hyReg;
      end
      if (regWrEn) begin
        case (regSel_e'(regAddr))
          RA_CTRL: enable <= regWrData[0];
          RA_BASE: begin
            baseReg <= regWrData[ADDR_W-1:ALIGN_W];
            lockReg <= regWrData[31];
          end
          RA_POS: begin
            xReg    <= regWrData[16 +: X_W];
            yReg    <= regWrData[0 +: Y_W];
            lockReg <= regWrData[31];
          end
          RA_HOT: begin
            hxReg   <= regWrData[0 +: HOT_W];
            hyReg   <= regWrData[16 +: HOT_W];
            lockReg <= regWrData[31];
          end
          RA_CLR0: color0 <= regWrData[CLR_W-1:0];
          RA_CLR1: color1 <= regWrData[CLR_W-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    regRdData = '0;
    case (regSel_e'(regAddr))
      RA_CTRL: regRdData[0] = enable;
      RA_BASE: begin
        regRdData[ADDR_W-1:ALIGN_W] = baseReg;
        regRdData[31] = lockReg;
      end
      RA_POS: begin
        regRdData[16 +: X_W] = xReg;
        regRdData[0 +: Y_W]  = yReg;
        regRdData[31]        = lockReg;
      end
      RA_HOT: begin
        regRdData[0 +: HOT_W]  = hxReg;
        regRdData[16 +: HOT_W] = hyReg;
        regRdData[31]          = lockReg;
      end
      RA_CLR0: regRdData[CLR_W-1:0] = color0;
      RA_CLR1: regRdData[CLR_W-1:0] = color1;
      default: ;
    endcase
  end

  // Row fetch: 16 consecutive byte reads issued after lineStart
  logic [Y_W-1:0]    rowDiff;
  logic              rowHit;
  logic [ADDR_W-1:0] imageStart, rowAddr;
  logic              busy, pend;
  logic [IDX_W-1:0]  cnt, pendIdx;

  assign rowDiff    = lineY - effY;
  assign rowHit     = enable && (lineY >= effY) && (rowDiff < Y_W'(CUR_DIM));
  assign imageStart = {effBase, {ALIGN_W{1'b0}}} - ADDR_W'(effHx)
                      - (ADDR_W'(effHy) << ALIGN_W);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy    <= 1'b0;
      cnt     <= '0;
      rowAddr <= '0;
      pend    <= 1'b0;
      pendIdx <= '0;
    end else begin
      pend    <= busy;
      pendIdx <= cnt;
      if (lineStart) begin
        busy    <= rowHit;
        cnt     <= '0;
        rowAddr <= imageStart + (ADDR_W'(rowDiff[ROW_W-1:0]) << IDX_W);
      end else if (busy) begin
        cnt <= cnt + 1'b1;
        if (cnt == IDX_W'(ROW_BYTES - 1)) busy <= 1'b0;
      end
    end
  end

  assign memRdEn        = busy;
  assign memAddr        = rowAddr + ADDR_W'(cnt);
  assign strobe.clrRow  = lineStart;
  assign strobe.ldByte  = pend;
  assign strobe.byteIdx = pendIdx;
endmodule

// File: rtl/cursorPixel.sv
module cursorPixel
  import cursorPkg::*;
#(
  parameter int X_W = 14
) (
  input  logic             clk,
  input  logic             rstN,
  input  fetchStrobe_t     strobe,
  input  logic [7:0]       memRdData,
  input  logic             enable,
  input  logic [X_W-1:0]   effX,
  input  logic [CLR_W-1:0] color0,
  input  logic [CLR_W-1:0] color1,
  input  logic [X_W-1:0]   dispWidth,
  input  logic             pixInValid,
  input  logic [X_W-1:0]   pixX,
  input  logic [31:0]      pixIn,
  output logic             pixOutValid,
  output logic [31:0]      pixOut
);
  localparam int HALF = ROW_BYTES / 2;

  logic [7:0] lineBuf [ROW_BYTES];
  logic       rowValid;

  always_ff @(posedge clk) begin
    if (strobe.ldByte) lineBuf[strobe.byteIdx] <= memRdData;
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobe.clrRow) rowValid <= 1'b0;
    else if (strobe.ldByte && strobe.byteIdx == IDX_W'(ROW_BYTES - 1)) rowValid <= 1'b1;
  end

  // Split the row into the AND plane and the XOR plane
  logic [CUR_DIM-1:0] andRow, xorRow;
  for (genvar b = 0; b < HALF; b++) begin : gPlanes
    assign andRow[CUR_DIM-1-8*b -: 8] = lineBuf[b];
    assign xorRow[CUR_DIM-1-8*b -: 8] = lineBuf[b + HALF];
  end

  logic [X_W-1:0]   col;
  logic [ROW_W-1:0] colIdx;
  logic             inCol, draw, andBit, xorBit;
  logic [31:0]      nextPix;

  assign col    = pixX - effX;
  assign colIdx = ~col[ROW_W-1:0];
  assign inCol  = (pixX >= effX) && (col < X_W'(CUR_DIM));
  assign draw   = enable && rowValid && inCol && (pixX < dispWidth);
  assign andBit = andRow[colIdx];
  assign xorBit = xorRow[colIdx];

  always_comb begin
    if (!draw)       nextPix = pixIn;
    else if (andBit) nextPix = xorBit ? ~pixIn : pixIn;
    else             nextPix = {(xorBit ? color1 : color0), 8'hFF};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pixOutValid <= 1'b0;
      pixOut      <= '0;
    end else begin
      pixOutValid <= pixInValid;
      pixOut      <= nextPix;
    end
  end
endmodule

// File: rtl/cursorOverlay.sv
module cursorOverlay
  import cursorPkg::*;
#(
  parameter int ADDR_W = 27,
  parameter int X_W    = 14,
  parameter int Y_W    = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [2:0]        regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  logic              lineStart,
  input  logic [Y_W-1:0]    lineY,
  input  logic [X_W-1:0]    dispWidth,
  output logic              memRdEn,
  output logic [ADDR_W-1:0] memAddr,
  input  logic [7:0]        memRdData,
  input  logic              pixInValid,
  input  logic [X_W-1:0]    pixX,
  input  logic [31:0]       pixIn,
  output logic              pixOutValid,
  output logic [31:0]       pixOut
);
  fetchStrobe_t     strobe;
  logic             enable;
  logic [X_W-1:0]   effX;
  logic [CLR_W-1:0] color0, color1;

  cursorCtrl #(.ADDR_W(ADDR_W), .X_W(X_W), .Y_W(Y_W)) uCtrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .lineStart(lineStart),
    .lineY(lineY), .memRdEn(memRdEn), .memAddr(memAddr), .strobe(strobe),
    .enable(enable), .effX(effX), .color0(color0), .color1(color1)
  );

  cursorPixel #(.X_W(X_W)) uPix (
    .clk(clk), .rstN(rstN), .strobe(strobe), .memRdData(memRdData),
    .enable(enable), .effX(effX), .color0(color0), .color1(color1),
    .dispWidth(dispWidth), .pixInValid(pixInValid), .pixX(pixX),
    .pixIn(pixIn), .pixOutValid(pixOutValid), .pixOut(pixOut)
  );
endmodule

// File: rtl/cursorOverlayChk.sv
module cursorOverlayChk #(
  parameter int ADDR_W = 27,
  parameter int X_W    = 14,
  parameter int Y_W    = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic              lineStart,
  input logic [Y_W-1:0]    lineY,
  input logic [X_W-1:0]    dispWidth,
  input logic              memRdEn,
  input logic [ADDR_W-1:0] memAddr,
  input logic              pixInValid,
  input logic [X_W-1:0]    pixX,
  input logic [31:0]       pixIn,
  input logic              pixOutValid,
  input logic [31:0]       pixOut,
  input logic              enable,
  input logic              lockBit,
  input logic [X_W-1:0]    effX,
  input logic [Y_W-1:0]    effY
);
  assert_latency_R12: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |-> pixOutValid == $past(pixInValid));

  assert_disabled_pass_R8: assert property (@(posedge clk) disable iff (!rstN)
    pixOutValid && !$past(enable) |-> pixOut == $past(pixIn));

  assert_clip_pass_R7: assert property (@(posedge clk) disable iff (!rstN)
    pixOutValid && $past(pixX >= dispWidth) |-> pixOut == $past(pixIn));

  assert_lock_freeze_R9: assert property (@(posedge clk) disable iff (!rstN)
    $past(lockBit) |-> $stable(effX) && $stable(effY));

  assert_no_fetch_R6: assert property (@(posedge clk) disable iff (!rstN)
    lineStart && (!enable || lineY < effY) |=> !memRdEn);

  assert_fetch_walk_R11: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn && $past(memRdEn) && !$past(lineStart) |-> memAddr == $past(memAddr) + 1'b1);
endmodule

bind cursorOverlay cursorOverlayChk #(.ADDR_W(ADDR_W), .X_W(X_W), .Y_W(Y_W)) uChk (
  .clk(clk), .rstN(rstN), .lineStart(lineStart), .lineY(lineY),
  .dispWidth(dispWidth), .memRdEn(memRdEn), .memAddr(memAddr),
  .pixInValid(pixInValid), .pixX(pixX), .pixIn(pixIn),
  .pixOutValid(pixOutValid), .pixOut(pixOut), .enable(enable),
  .lockBit(uCtrl.lockReg), .effX(effX), .effY(uCtrl.effY)
);

// File: tb/cursorOverlay_test.sv
`timescale 1ns/1ps
module cursorOverlay_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        lineStart = 1'b0;
  logic [11:0] lineY = '0;
  logic [13:0] dispWidth = 14'd640;
  logic        memRdEn;
  logic [26:0] memAddr;
  logic [7:0]  memRdData = '0;
  logic        pixInValid = 1'b0;
  logic [13:0] pixX = '0;
  logic [31:0] pixIn = '0;
  logic        pixOutValid;
  logic [31:0] pixOut;

  int nChecks = 0, nFails = 0;
  bit finished = 0;

  // Bench model of the register state
  int  mEn = 0, mLock = 0;
  int  sOff = 0, sX = 0, sY = 0, sHx = 0, sHy = 0;
  int  eOff = 0, eX = 0, eY = 0, eHx = 0, eHy = 0;
  int  mC0 = 0, mC1 = 0;

  logic [31:0] expQ[$];
  string       tagQ[$];
  int          xQ[$];

  always #4 clk = ~clk;

  cursorOverlay uut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .lineStart(lineStart),
    .lineY(lineY), .dispWidth(dispWidth), .memRdEn(memRdEn), .memAddr(memAddr),
    .memRdData(memRdData), .pixInValid(pixInValid), .pixX(pixX), .pixIn(pixIn),
    .pixOutValid(pixOutValid), .pixOut(pixOut)
  );

  function automatic logic [7:0] memByte(input int a);
    int b;
    b = a & 32'hFFF;
    return 8'((b * 37) ^ (b >> 3) ^ 8'h5A);
  endfunction

  always @(posedge clk) if (memRdEn) memRdData <= memByte(int'(memAddr));

  function automatic logic [31:0] expPix(input int x, input int y, input logic [31:0] pin);
    int start, row, col;
    logic [7:0] ab, xb;
    logic a, xo;
    if (mEn == 0 || y < eY || y >= eY + 64 || x < eX || x >= eX + 64 || x >= int'(dispWidth))
      return pin;
    start = eOff - eHx - 16 * eHy;
    row = y - eY;
    col = x - eX;
    ab = memByte(start + row * 16 + col / 8);
    xb = memByte(start + row * 16 + 8 + col / 8);
    a  = ab[7 - col % 8];
    xo = xb[7 - col % 8];
    if (a) return xo ? ~pin : pin;
    return {(xo ? mC1[23:0] : mC0[23:0]), 8'hFF};
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s got=%08h exp=%08h", tag, got, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    if (mLock == 0) begin eOff = sOff; eX = sX; eY = sY; eHx = sHx; eHy = sHy; end
    case (a)
      0: mEn = int'(d[0]);
      1: begin sOff = int'(d & 32'h07FFFFF0); mLock = int'(d[31]); end
      2: begin sX = int'(d[29:16]); sY = int'(d[11:0]); mLock = int'(d[31]); end
      3: begin sHx = int'(d[5:0]); sHy = int'(d[21:16]); mLock = int'(d[31]); end
      4: mC0 = int'(d[23:0]);
      5: mC1 = int'(d[23:0]);
      default: ;
    endcase
    if (mLock == 0) begin eOff = sOff; eX = sX; eY = sY; eHx = sHx; eHy = sHy; end
    @(posedge clk); #1;
    regWrEn = 1'b1; regAddr = 3'(a); regWrData = d;
    @(posedge clk); #1;
    regWrEn = 1'b0;
  endtask

  task automatic rdChk(input int a, input logic [31:0] exp, input string tag);
    @(posedge clk); #1;
    regAddr = 3'(a);
    #1;
    check(tag, regRdData, exp);
  endtask

  // Driver: one scanline, expected pixels pushed into the scoreboard
  task automatic doLine(input int y, input int x0, input int x1, input string tag);
    @(posedge clk); #1;
    lineStart = 1'b1; lineY = 12'(y);
    @(posedge clk); #1;
    lineStart = 1'b0;
    repeat (22) @(posedge clk);
    for (int x = x0; x <= x1; x++) begin
      logic [31:0] p;
      @(posedge clk); #1;
      p = 32'h1357_9BDF ^ (32'(x) * 32'h0001_0003) ^ (32'(y) << 8);
      pixInValid = 1'b1; pixX = 14'(x); pixIn = p;
      expQ.push_back(expPix(x, y, p));
      tagQ.push_back(tag);
      xQ.push_back(x);
    end
    @(posedge clk); #1;
    pixInValid = 1'b0;
    repeat (3) @(posedge clk);
  endtask

  // Monitor: compare each produced pixel with the head of the queue
  always @(negedge clk) begin
    if (rstN && pixOutValid) begin
      if (expQ.size() == 0) begin
        nChecks++; nFails++;
        $display("FAIL R12 unexpected output got=%08h exp=none", pixOut);
      end else begin
        logic [31:0] e;
        string t;
        int x;
        e = expQ.pop_front(); t = tagQ.pop_front(); x = xQ.pop_front();
        check($sformatf("%s x=%0d", t, x), pixOut, e);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog expired got=running exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rstN = 1'b1;
    // R1: reset state
    for (int a = 0; a < 6; a++) rdChk(a, 32'h0, "R1 reset read");
    doLine(0, 0, 20, "R1 reset passthrough");

    wr(4, 32'hFF11_2233);
    wr(5, 32'h0044_5566);
    wr(1, 32'h0000_0200);
    wr(2, (32'd10 << 16) | 32'd20);
    wr(0, 32'h1);
    // R2 R3 R4 R5: plane decode on first, middle and last rows
    doLine(20, 0, 90, "R2/R3/R4/R5 row0");
    doLine(52, 0, 90, "R5 mid row");
    doLine(83, 0, 90, "R5 last row");
    // R6: lines just outside
    doLine(84, 0, 90, "R6 below");
    doLine(19, 0, 90, "R6 above");
    // R7: clipping at display width
    dispWidth = 14'd40;
    doLine(30, 0, 60, "R7 clip");
    dispWidth = 14'd640;
    // R11: hot-spot moves image start
    wr(3, (32'd2 << 16) | 32'd3);
    doLine(25, 0, 90, "R11 hotspot");
    // R9 R10: lock
    wr(2, 32'h8000_0000 | (32'd100 << 16) | 32'd200);
    rdChk(2, 32'h8000_0000 | (32'd100 << 16) | 32'd200, "R10 pos lock read");
    rdChk(3, 32'h8002_0003, "R10 hot lock read");
    doLine(25, 0, 90, "R9 locked old pos");
    doLine(200, 90, 180, "R9 locked new pos unused");
    wr(3, (32'd2 << 16) | 32'd3);
    doLine(200, 90, 180, "R9 released");
    // R10: write masks
    wr(1, 32'hFFFF_FFFF);
    rdChk(1, 32'h87FF_FFF0, "R10 base mask");
    wr(2, 32'hFFFF_FFFF);
    rdChk(2, 32'hBFFF_0FFF, "R10 pos mask");
    wr(3, 32'hFFFF_FFFF);
    rdChk(3, 32'h803F_003F, "R10 hot mask");
    wr(4, 32'hFFFF_FFFF);
    rdChk(4, 32'h00FF_FFFF, "R10 colour mask");
    wr(1, 32'h0000_0400);
    wr(3, 32'h0);
    wr(2, (32'd5 << 16) | 32'd7);
    doLine(40, 0, 80, "R11 new base");
    // R8: disabled
    wr(0, 32'h0);
    doLine(40, 0, 80, "R8 disabled");
    repeat (4) @(posedge clk);
    check("R12 scoreboard drained", 32'(expQ.size()), 32'h0);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule